// File: doc/BRIEF.md
# Incremental Axis-Parameter Phase Sequencer

This block prepares the parameters of a single scan axis in small increments. A parent controller strikes it with a one-cycle call strobe. Each call takes exactly one action and then answers with a one-cycle reply strobe. The action is one of three: finish the current phase, advance a shared phase counter by one, or do nothing once all work is finished.

The work falls into three phases that always run in the same order: step size, then magnification, then gray scale. All three share one counter. Each phase ends when the counter equals that phase's target, and the finished phase raises its own flag. The scan-axis bit and the rotation bit choose which of two step-size targets applies. The gray-scale phase can also be satisfied at once by the raster-format flag or the constant-rate bit. When the gray-scale phase finishes, the X transfer register is loaded with zero. The Z transfer register is loaded with zero as well, but only for a rotated scan axis.

Top module: `axis_param_seq`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, the block holds these values: `phase_count` = 0, all three phase flags = 0, `reply` = 0, and both transfer registers = `XFER_INIT` (default 2'b11).
- R2: A call sampled high at a clock edge while the block is idle causes `reply` to go high for exactly one cycle, starting after the second following edge. The phase flags and the counter already show the new values in that reply cycle. While a call is being processed, further call strobes are ignored.
- R3: The step-size target is chosen as follows:
  - When `axis_sel`=1 and `rot_sel`=0, the target is `step_tgt_a`.
  - When `axis_sel`=1 and `rot_sel`=1, the target is `step_tgt_b`.
  - When `axis_sel`=0, no step-size target can match.
- R4: While `step_done`=0, a call that finds the counter equal to the selected step target clears the counter and sets `step_done`.
- R5: A call that completes no phase while some phase is still open increments `phase_count` by one, modulo 2^CNT_W.
- R6: While `step_done`=1 and `mag_done`=0, a call that finds the counter equal to `mag_tgt` clears the counter and sets `mag_done`.
- R7: While `mag_done`=1 and `gray_done`=0, a call sets `gray_done` when either of these holds:
  - the counter equals `gray_tgt` after zero-extension;
  - `raster_fmt`=1 or `const_rate`=1.
  The counter is left unchanged.
- R8: The call that sets `gray_done` loads `xfer_x` with 0. It also loads `xfer_z` with 0 when `axis_sel`=1 and `rot_sel`=1; otherwise `xfer_z` keeps its value.
- R9: A call completes at most one phase. The phase flags only ever become set, in the order step, magnification, gray scale. Outside a call's update and `clr`, the counter and the flags do not change.
- R10: Once all three flags are set, a call still replies and changes neither the counter nor any flag nor any transfer register.
- R11: A high `clr` at a clock edge zeroes the counter, all three flags and both transfer registers. It takes priority over a call update at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of counter, flags and transfer registers |
| call | input | 1 | Call strobe from the parent controller |
| axis_sel | input | 1 | Scan-axis bit |
| rot_sel | input | 1 | Scan-axis rotation bit |
| const_rate | input | 1 | Constant-rate bit; satisfies the gray-scale phase |
| raster_fmt | input | 1 | Raster-format flag; satisfies the gray-scale phase |
| step_tgt_a | input | CNT_W | Step-size target for an unrotated axis |
| step_tgt_b | input | CNT_W | Step-size target for a rotated axis |
| mag_tgt | input | CNT_W | Magnification target |
| gray_tgt | input | GRAY_W | Gray-scale target |
| reply | output | 1 | One-cycle reply strobe |
| step_done | output | 1 | Step-size phase finished |
| mag_done | output | 1 | Magnification phase finished |
| gray_done | output | 1 | Gray-scale phase finished |
| xfer_x | output | XFER_W | X transfer register |
| xfer_z | output | XFER_W | Z transfer register |
| phase_count | output | CNT_W | Shared phase counter |

## Verification
The hardest state to reach is gray-scale completion on a rotated axis, because that is the only case where the Z transfer register is loaded. Reaching it takes a long chain of calls through the step and magnification phases. The bench shortens the chain with small targets and a zero magnification target. It gives the unrotated target a value the counter passes on the way, so a wrong target choice would finish the step phase early. Calls held high across the busy window, and a long run with the axis bit low that wraps the counter, cover the ignore and no-match paths.

// File: rtl/axp_pkg.sv
package axp_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_EVAL  = 2'd1,
    HS_REPLY = 2'd2
  } hs_state_e;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_A    = 2'd1,
    PICK_B    = 2'd2
  } step_pick_e;

  typedef struct packed {
    logic step;
    logic mag;
    logic gray;
  } phase_flags_t;

  // Which step-size target the axis and rotation bits select.
  function automatic step_pick_e pick_step(input logic axis, input logic rot);
    if (!axis)    return PICK_NONE;
    else if (rot) return PICK_B;
    else          return PICK_A;
  endfunction

endpackage

// File: rtl/axp_handshake.sv
module axp_handshake
  import axp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic call,
  output logic eval_fire,
  output logic reply
);

  hs_state_e st_q, st_d;

  always_comb begin
    case (st_q)
      HS_IDLE:  st_d = call ? HS_EVAL : HS_IDLE;
      HS_EVAL:  st_d = HS_REPLY;
      HS_REPLY: st_d = HS_IDLE;
      default:  st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_IDLE;
    else        st_q <= st_d;
  end

  assign eval_fire = (st_q == HS_EVAL);
  assign reply     = (st_q == HS_REPLY);

endmodule

// File: rtl/axp_phase_eval.sv
module axp_phase_eval
  import axp_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int GRAY_W = 2
) (
  input  logic [CNT_W-1:0]  cnt,
  input  phase_flags_t      flags,
  input  logic              axis_sel,
  input  logic              rot_sel,
  input  logic              const_rate,
  input  logic              raster_fmt,
  input  logic [CNT_W-1:0]  tgt_a,
  input  logic [CNT_W-1:0]  tgt_b,
  input  logic [CNT_W-1:0]  tgt_mag,
  input  logic [GRAY_W-1:0] tgt_gray,
  output logic [CNT_W-1:0]  cnt_nx,
  output phase_flags_t      flags_nx,
  output logic              step_hit,
  output logic              mag_hit,
  output logic              gray_hit,
  output logic              cnt_bump,
  output logic              load_z
);

  function automatic logic step_match(input step_pick_e pk,
                                      input logic [CNT_W-1:0] c,
                                      input logic [CNT_W-1:0] a,
                                      input logic [CNT_W-1:0] b);
    case (pk)
      PICK_A:  return c == a;
      PICK_B:  return c == b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] widen_gray(input logic [GRAY_W-1:0] g);
    return CNT_W'(g);
  endfunction

  step_pick_e pick;
  logic       gray_ok;
  logic       all_done;

  always_comb begin
    pick     = pick_step(axis_sel, rot_sel);
    gray_ok  = raster_fmt || const_rate || (cnt == widen_gray(tgt_gray));
    all_done = flags.step && flags.mag && flags.gray;

    step_hit = !flags.step && step_match(pick, cnt, tgt_a, tgt_b);
    mag_hit  = flags.step && !flags.mag && (cnt == tgt_mag);
    gray_hit = flags.step && flags.mag && !flags.gray && gray_ok;
    cnt_bump = !all_done && !(step_hit || mag_hit || gray_hit);

    if (step_hit || mag_hit) cnt_nx = '0;
    else if (cnt_bump)       cnt_nx = cnt + 1'b1;
    else                     cnt_nx = cnt;

    flags_nx.step = flags.step | step_hit;
    flags_nx.mag  = flags.mag  | mag_hit;
    flags_nx.gray = flags.gray | gray_hit;

    load_z = gray_hit && (pick == PICK_B);
  end

endmodule

// File: rtl/axp_state_regs.sv
module axp_state_regs
  import axp_pkg::*;
#(
  parameter int                CNT_W     = 3,
  parameter int                XFER_W    = 2,
  parameter logic [XFER_W-1:0] XFER_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              eval_fire,
  input  logic [CNT_W-1:0]  cnt_nx,
  input  phase_flags_t      flags_nx,
  input  logic              gray_hit,
  input  logic              load_z,
  output logic [CNT_W-1:0]  cnt,
  output phase_flags_t      flags,
  output logic [XFER_W-1:0] xfer_x,
  output logic [XFER_W-1:0] xfer_z
);

  localparam int LANES = 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      flags <= '0;
    end else if (clr) begin
      cnt   <= '0;
      flags <= '0;
    end else if (eval_fire) begin
      cnt   <= cnt_nx;
      flags <= flags_nx;
    end
  end

  logic [LANES-1:0]  lane_load;
  logic [XFER_W-1:0] lane_q [LANES];

  assign lane_load[0] = eval_fire && gray_hit;
  assign lane_load[1] = eval_fire && load_z;

  for (genvar i = 0; i < LANES; i++) begin : g_xfer
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            lane_q[i] <= XFER_INIT;
      else if (clr)          lane_q[i] <= '0;
      else if (lane_load[i]) lane_q[i] <= '0;
    end
  end

  assign xfer_x = lane_q[0];
  assign xfer_z = lane_q[1];

endmodule

// File: rtl/axis_param_seq.sv
module axis_param_seq
  import axp_pkg::*;
#(
  parameter int                CNT_W     = 3,
  parameter int                GRAY_W    = 2,
  parameter int                XFER_W    = 2,
  parameter logic [XFER_W-1:0] XFER_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              call,
  input  logic              axis_sel,
  input  logic              rot_sel,
  input  logic              const_rate,
  input  logic              raster_fmt,
  input  logic [CNT_W-1:0]  step_tgt_a,
  input  logic [CNT_W-1:0]  step_tgt_b,
  input  logic [CNT_W-1:0]  mag_tgt,
  input  logic [GRAY_W-1:0] gray_tgt,
  output logic              reply,
  output logic              step_done,
  output logic              mag_done,
  output logic              gray_done,
  output logic [XFER_W-1:0] xfer_x,
  output logic [XFER_W-1:0] xfer_z,
  output logic [CNT_W-1:0]  phase_count
);

  // Named internal events, visible to the bound checker.
  logic         eval_fire;
  logic         step_hit;
  logic         mag_hit;
  logic         gray_hit;
  logic         cnt_bump;
  logic         load_z;
  logic [CNT_W-1:0] cnt_nx;
  phase_flags_t flags_q, flags_nx;

  axp_handshake u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .call      (call),
    .eval_fire (eval_fire),
    .reply     (reply)
  );

  axp_phase_eval #(.CNT_W(CNT_W), .GRAY_W(GRAY_W)) u_eval (
    .cnt        (phase_count),
    .flags      (flags_q),
    .axis_sel   (axis_sel),
    .rot_sel    (rot_sel),
    .const_rate (const_rate),
    .raster_fmt (raster_fmt),
    .tgt_a      (step_tgt_a),
    .tgt_b      (step_tgt_b),
    .tgt_mag    (mag_tgt),
    .tgt_gray   (gray_tgt),
    .cnt_nx     (cnt_nx),
    .flags_nx   (flags_nx),
    .step_hit   (step_hit),
    .mag_hit    (mag_hit),
    .gray_hit   (gray_hit),
    .cnt_bump   (cnt_bump),
    .load_z     (load_z)
  );

  axp_state_regs #(.CNT_W(CNT_W), .XFER_W(XFER_W), .XFER_INIT(XFER_INIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .eval_fire (eval_fire),
    .cnt_nx    (cnt_nx),
    .flags_nx  (flags_nx),
    .gray_hit  (gray_hit),
    .load_z    (load_z),
    .cnt       (phase_count),
    .flags     (flags_q),
    .xfer_x    (xfer_x),
    .xfer_z    (xfer_z)
  );

  assign step_done = flags_q.step;
  assign mag_done  = flags_q.mag;
  assign gray_done = flags_q.gray;

endmodule

// File: rtl/axp_checker.sv
module axp_checker #(
  parameter int CNT_W  = 3,
  parameter int XFER_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              call,
  input logic              reply,
  input logic              eval_fire,
  input logic              step_hit,
  input logic              mag_hit,
  input logic              gray_hit,
  input logic              cnt_bump,
  input logic [CNT_W-1:0]  phase_count,
  input logic              step_done,
  input logic              mag_done,
  input logic              gray_done,
  input logic [XFER_W-1:0] xfer_x
);

  p_reply_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reply |=> !reply);

  p_reply_after_call_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reply |-> $past(call, 2));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_fire && cnt_bump && !clr) |=> (phase_count == $past(phase_count) + 1'b1));

  p_mag_needs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mag_done |-> step_done);

  p_gray_needs_mag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gray_done |-> mag_done);

  p_xfer_on_gray_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gray_done) |-> (xfer_x == '0));

  p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire |-> $onehot0({step_hit, mag_hit, gray_hit, cnt_bump}));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_fire && !clr) |=> ($stable(phase_count) && $stable({step_done, mag_done, gray_done})));

  p_idle_when_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_fire && gray_done && !clr) |=> $stable(phase_count));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_count == '0 && !step_done && !mag_done && !gray_done && xfer_x == '0));

endmodule

bind axis_param_seq axp_checker #(.CNT_W(CNT_W), .XFER_W(XFER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .call        (call),
  .reply       (reply),
  .eval_fire   (eval_fire),
  .step_hit    (step_hit),
  .mag_hit     (mag_hit),
  .gray_hit    (gray_hit),
  .cnt_bump    (cnt_bump),
  .phase_count (phase_count),
  .step_done   (step_done),
  .mag_done    (mag_done),
  .gray_done   (gray_done),
  .xfer_x      (xfer_x)
);

// File: tb/axis_param_seq_test.sv
module axis_param_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       call = 1'b0;
  logic       axis_sel = 1'b0, rot_sel = 1'b0, const_rate = 1'b0, raster_fmt = 1'b0;
  logic [2:0] step_tgt_a = '0, step_tgt_b = '0, mag_tgt = '0;
  logic [1:0] gray_tgt = '0;
  logic       reply, step_done, mag_done, gray_done;
  logic [1:0] xfer_x, xfer_z;
  logic [2:0] phase_count;

  axis_param_seq uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .call(call),
    .axis_sel(axis_sel), .rot_sel(rot_sel), .const_rate(const_rate), .raster_fmt(raster_fmt),
    .step_tgt_a(step_tgt_a), .step_tgt_b(step_tgt_b), .mag_tgt(mag_tgt), .gray_tgt(gray_tgt),
    .reply(reply), .step_done(step_done), .mag_done(mag_done), .gray_done(gray_done),
    .xfer_x(xfer_x), .xfer_z(xfer_z), .phase_count(phase_count)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int         due;
    logic [2:0] cnt;
    logic [2:0] flg;
    logic [1:0] x;
    logic [1:0] z;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference state kept by the bench.
  logic [2:0] m_cnt;
  logic       m_sd, m_md, m_gd;
  logic [1:0] m_x, m_z;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    m_cnt = 3'd0; m_sd = 1'b0; m_md = 1'b0; m_gd = 1'b0;
    m_x = 2'b11; m_z = 2'b11;
  endtask

  // Bench restatement of one call, written per phase.
  task automatic model_call();
    int phase;
    bit tgt_hit;
    phase = m_sd ? (m_md ? (m_gd ? 3 : 2) : 1) : 0;
    case (phase)
      0: begin
        tgt_hit = axis_sel && ((rot_sel && m_cnt == step_tgt_b) || (!rot_sel && m_cnt == step_tgt_a));
        if (tgt_hit) begin m_cnt = 3'd0; m_sd = 1'b1; end
        else m_cnt = m_cnt + 3'd1;
      end
      1: begin
        if (m_cnt == mag_tgt) begin m_cnt = 3'd0; m_md = 1'b1; end
        else m_cnt = m_cnt + 3'd1;
      end
      2: begin
        tgt_hit = raster_fmt || const_rate || (m_cnt == {1'b0, gray_tgt});
        if (tgt_hit) begin
          m_gd = 1'b1;
          m_x  = 2'b00;
          if (axis_sel && rot_sel) m_z = 2'b00;
        end else m_cnt = m_cnt + 3'd1;
      end
      default: ;
    endcase
  endtask

  // Driver: pushes the expected reply, then strobes call for 'hold' cycles.
  task automatic do_call(input int hold, input string tag);
    exp_t e;
    model_call();
    @(negedge clk);
    e.due = cyc + 2;
    e.cnt = m_cnt;
    e.flg = {m_sd, m_md, m_gd};
    e.x   = m_x;
    e.z   = m_z;
    e.tag = tag;
    exp_q.push_back(e);
    call = 1'b1;
    for (int i = 1; i < hold; i++) @(negedge clk);
    @(negedge clk);
    call = 1'b0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R2 reply pending"}, exp_q.size(), 0);
  endtask

  // Monitor: pops and compares on every reply.
  always @(negedge clk) begin
    if (rst_n && reply) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 reply without accepted call", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc == e.due, {e.tag, " R2 reply cycle"}, cyc, e.due);
        chk(phase_count == e.cnt, {e.tag, " count"}, phase_count, e.cnt);
        chk({step_done, mag_done, gray_done} == e.flg, {e.tag, " flags"},
            {step_done, mag_done, gray_done}, e.flg);
        chk(xfer_x == e.x, {e.tag, " xfer_x"}, xfer_x, e.x);
        chk(xfer_z == e.z, {e.tag, " xfer_z"}, xfer_z, e.z);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(phase_count == 3'd0 && reply == 1'b0, "R1 count/reply in reset", phase_count, 0);
    chk({step_done, mag_done, gray_done} == 3'b000, "R1 flags in reset",
        {step_done, mag_done, gray_done}, 0);
    chk(xfer_x == 2'b11 && xfer_z == 2'b11, "R1 xfer init", {xfer_x, xfer_z}, 15);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    // Sequence A: unrotated axis, step target A
    axis_sel = 1'b1; rot_sel = 1'b0;
    step_tgt_a = 3'd2; step_tgt_b = 3'd5; mag_tgt = 3'd1; gray_tgt = 2'd2;
    do_reset();
    do_call(3, "R2 busy-ignore / R5 bump");
    do_call(1, "R5 bump");
    do_call(1, "R3 R4 step target A");
    do_call(1, "R5 mag bump");
    do_call(1, "R6 mag match");
    do_call(1, "R5 gray bump 1");
    do_call(1, "R5 gray bump 2");
    do_call(1, "R7 R8 gray match, z kept");
    do_call(1, "R10 all done");
    do_call(2, "R10 all done again");
    // R11: synchronous clear
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_cnt = 3'd0; m_sd = 1'b0; m_md = 1'b0; m_gd = 1'b0; m_x = 2'b00; m_z = 2'b00;
    chk(phase_count == 3'd0 && {step_done, mag_done, gray_done} == 3'b000, "R11 clear count/flags",
        {phase_count, step_done, mag_done, gray_done}, 0);
    chk(xfer_x == 2'b00 && xfer_z == 2'b00, "R11 clear xfer", {xfer_x, xfer_z}, 0);
    do_call(1, "R11 restart after clear");

    // Sequence B: rotated axis, target B, zero mag target, raster shortcut
    axis_sel = 1'b1; rot_sel = 1'b1;
    step_tgt_a = 3'd1; step_tgt_b = 3'd3; mag_tgt = 3'd0; gray_tgt = 2'd3;
    raster_fmt = 1'b1; const_rate = 1'b0;
    do_reset();
    for (int i = 0; i < 3; i++) do_call(1, "R3 target A not used when rotated");
    do_call(1, "R3 R4 step target B");
    do_call(1, "R6 mag zero target");
    do_call(1, "R7 raster shortcut R8 z loaded");

    // Sequence C: axis bit low, no step match, counter wraps
    axis_sel = 1'b0; rot_sel = 1'b0; raster_fmt = 1'b0;
    step_tgt_a = 3'd0; step_tgt_b = 3'd0;
    do_reset();
    for (int i = 0; i < 10; i++) do_call(1, "R3 no target R5 wrap");

    // Sequence D: constant-rate shortcut on unrotated axis
    axis_sel = 1'b1; rot_sel = 1'b0; const_rate = 1'b1;
    step_tgt_a = 3'd0; mag_tgt = 3'd0; gray_tgt = 2'd3;
    do_reset();
    do_call(1, "R4 immediate step");
    do_call(1, "R9 one phase per call, mag");
    do_call(1, "R7 const-rate shortcut R8 z kept");
    do_call(1, "R10 done");

    repeat (4) @(negedge clk);
    summary();
  end

endmodule